// File: doc/BRIEF.md
# Quad-LUT Logic Analyzer Trigger

This block decides when a logic analyzer capture should trigger. It watches a stream of parallel channel samples. The channels are split into groups of four, called quads. The four bits of a quad form a 4-bit address into a 16-entry truth table. There is one such table per quad for each of several pattern units.

Unit 0 is the level (state) pattern. The remaining units are edge detectors. A unit matches a sample when every quad's table holds a 1 at the address given by that quad. Each edge detector's previous and current match results are packed into an index. That index selects one bit of a programmable combining table, so rise, fall and OR-ed mixes of them are defined entirely by table contents.

The host fills the tables through a small register port. First it writes a staging word that holds one bit for every (unit, quad) table. Then a select write commits that word into one table address. Once armed, the block emits a one-cycle trigger pulse and disarms itself.

Top module: `quad_lut_trigger`

## Requirements
- R1: After reset `trig_o` and `armed_o` are 0, and all truth tables are cleared, so no sample can match until tables are loaded.
- R2: Channel bits 4q..4q+3 of `smp_data_i` form the table address for quad q. A unit matches only when the table bit at that address is 1 for every quad.
- R3: Register 0 is the staging word; bit u*NUM_QUADS+q is the entry for unit u, quad q. A write to register 1 whose data bits [7:4] equal 3 copies the staging word into address data[3:0] of every table. Register-1 writes with any other value in bits [7:4] leave the tables unchanged.
- R4: With edge mode off, an armed block triggers on any valid sample that matches the state unit.
- R5: With edge mode on, detector k places its previous-sample match at index bit 2k and its current-sample match at bit 2k+1. The trigger needs a state match and a 1 in the combining table (register 2, bit = index).
- R6: The edge history is invalid after reset and after any table write. The first valid sample that follows cannot fire in edge mode.
- R7: The trigger is a single-cycle pulse, one clock after the qualifying sample. The block then disarms and stays silent until it is armed again.
- R8: A write to register 0, 1 or 2 disarms the block. A sample presented in the same cycle as such a write cannot fire.
- R9: Register 3 bit 0 arms (1) or disarms (0) the block. Register 3 bit 1 selects edge mode.
- R10: Cycles with `smp_valid_i` low never fire and do not advance the edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select: 0 staging, 1 commit, 2 combining table, 3 control |
| cfg_wdata_i | input | CFG_W (16) | Register write data |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_data_i | input | 4*NUM_QUADS (16) | Channel sample |
| trig_o | output | 1 | One-cycle trigger pulse |
| armed_o | output | 1 | Block is armed |

## Verification
The bench builds the block with its defaults: four quads (16 channels), two edge detectors and 16-bit configuration words. This gives a full 12-bit staging word and a 16-entry combining table. At this size a full value/mask pattern across all quads can be loaded. Both edge detectors can be active together, so a rise on one and a fall on the other are each shown to fire through the combining table, and their index bit positions are checked.

// File: rtl/qlt_pkg.sv
package qlt_pkg;
  localparam int unsigned QUAD_BITS = 4;
  localparam int unsigned LUT_DEPTH = 1 << QUAD_BITS;

  typedef enum logic [1:0] {
    REG_STAGE   = 2'd0,
    REG_SELECT  = 2'd1,
    REG_COMBINE = 2'd2,
    REG_CTRL    = 2'd3
  } reg_sel_e;

  localparam logic [3:0] COMMIT_CODE   = 4'h3;
  localparam int unsigned CTRL_ARM_BIT  = 0;
  localparam int unsigned CTRL_EDGE_BIT = 1;
endpackage

// File: rtl/qlt_cfg.sv
module qlt_cfg
  import qlt_pkg::*;
#(
  parameter int unsigned NUM_QUADS  = 4,
  parameter int unsigned NUM_UNITS  = 3,
  parameter int unsigned CFG_W      = 16,
  parameter int unsigned COMB_DEPTH = 16,
  localparam int unsigned NUM_TBL   = NUM_UNITS * NUM_QUADS,
  localparam int unsigned LUT_BITS  = NUM_TBL * LUT_DEPTH
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [1:0]            addr_i,
  input  logic [CFG_W-1:0]      wdata_i,
  output logic [LUT_BITS-1:0]   lut_o,
  output logic [COMB_DEPTH-1:0] comb_o,
  output logic                  edge_en_o,
  output logic                  tbl_wr_o,
  output logic                  arm_wr_o,
  output logic                  arm_val_o
);
  reg_sel_e sel;
  logic [NUM_TBL-1:0]    stage_q, stage_d;
  logic [LUT_BITS-1:0]   lut_q, lut_d;
  logic [COMB_DEPTH-1:0] comb_q, comb_d;
  logic                  edge_en_q, edge_en_d;
  logic                  commit;
  logic [QUAD_BITS-1:0]  lut_addr;

  assign sel      = reg_sel_e'(addr_i);
  assign lut_addr = wdata_i[QUAD_BITS-1:0];
  assign commit   = we_i && (sel == REG_SELECT) && (wdata_i[7:4] == COMMIT_CODE);

  always_comb begin
    stage_d   = stage_q;
    lut_d     = lut_q;
    comb_d    = comb_q;
    edge_en_d = edge_en_q;
    if (we_i && sel == REG_STAGE) stage_d = wdata_i[NUM_TBL-1:0];
    if (we_i && sel == REG_COMBINE) comb_d = wdata_i[COMB_DEPTH-1:0];
    if (we_i && sel == REG_CTRL) edge_en_d = wdata_i[CTRL_EDGE_BIT];
    if (commit) begin
      for (int i = 0; i < int'(NUM_TBL); i++) begin
        lut_d[i*LUT_DEPTH + int'(lut_addr)] = stage_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= '0;
      lut_q     <= '0;
      comb_q    <= '0;
      edge_en_q <= 1'b0;
    end else begin
      stage_q   <= stage_d;
      lut_q     <= lut_d;
      comb_q    <= comb_d;
      edge_en_q <= edge_en_d;
    end
  end

  assign lut_o     = lut_q;
  assign comb_o    = comb_q;
  assign edge_en_o = edge_en_q;
  assign tbl_wr_o  = we_i && (sel != REG_CTRL);
  assign arm_wr_o  = we_i && (sel == REG_CTRL);
  assign arm_val_o = wdata_i[CTRL_ARM_BIT];

  // R3: a select write without the commit code must not alter any table
  p_no_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == REG_SELECT && wdata_i[7:4] != COMMIT_CODE) |=> $stable(lut_q));

  // R3: tables only change after a commit write
  p_lut_changes_on_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel == REG_SELECT) |=> $stable(lut_q));
endmodule

// File: rtl/qlt_match.sv
module qlt_match
  import qlt_pkg::*;
#(
  parameter int unsigned NUM_QUADS = 4,
  localparam int unsigned CH       = NUM_QUADS * QUAD_BITS
) (
  input  logic [NUM_QUADS*LUT_DEPTH-1:0] tbl_i,
  input  logic [CH-1:0]                  data_i,
  output logic                           match_o
);
  logic [NUM_QUADS-1:0] hit;

  for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
    logic [LUT_DEPTH-1:0] row;
    logic [QUAD_BITS-1:0] quad_addr;
    assign row       = tbl_i[q*LUT_DEPTH +: LUT_DEPTH];
    assign quad_addr = data_i[q*QUAD_BITS +: QUAD_BITS];
    assign hit[q]    = row[quad_addr];
  end

  assign match_o = &hit;
endmodule

// File: rtl/qlt_fire.sv
module qlt_fire
  import qlt_pkg::*;
#(
  parameter int unsigned NUM_EDGE = 2,
  localparam int unsigned CIW        = 2 * NUM_EDGE,
  localparam int unsigned COMB_DEPTH = 1 << CIW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  smp_valid_i,
  input  logic                  state_m_i,
  input  logic [NUM_EDGE-1:0]   edge_m_i,
  input  logic [COMB_DEPTH-1:0] comb_i,
  input  logic                  edge_en_i,
  input  logic                  tbl_wr_i,
  input  logic                  arm_wr_i,
  input  logic                  arm_val_i,
  output logic                  trig_o,
  output logic                  armed_o
);
  logic [NUM_EDGE-1:0] prev_q, prev_d;
  logic                hist_q, hist_d;
  logic                armed_q, armed_d;
  logic                trig_q, trig_d;
  logic [CIW-1:0]      idx;
  logic                cond, fire;

  always_comb begin
    for (int k = 0; k < int'(NUM_EDGE); k++) begin
      idx[2*k]   = prev_q[k];
      idx[2*k+1] = edge_m_i[k];
    end
  end

  assign cond = state_m_i && (!edge_en_i || (hist_q && comb_i[idx]));
  assign fire = smp_valid_i && armed_q && !tbl_wr_i && cond;

  always_comb begin
    prev_d  = prev_q;
    hist_d  = hist_q;
    armed_d = armed_q;
    trig_d  = fire;
    if (smp_valid_i) begin
      prev_d = edge_m_i;
      hist_d = 1'b1;
    end
    if (tbl_wr_i) hist_d = 1'b0;
    if (tbl_wr_i)      armed_d = 1'b0;
    else if (arm_wr_i) armed_d = arm_val_i;
    else if (fire)     armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      hist_q  <= 1'b0;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      hist_q  <= hist_d;
      armed_q <= armed_d;
      trig_q  <= trig_d;
    end
  end

  assign trig_o  = trig_q;
  assign armed_o = armed_q;

  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> !trig_q);

  p_fire_when_armed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> $past(armed_q));

  p_write_disarms_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_i |=> (!trig_q && !armed_q));

  p_idle_no_fire_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !trig_q);

  p_no_history_no_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_en_i && !hist_q) |=> !trig_q);
endmodule

// File: rtl/quad_lut_trigger.sv
module quad_lut_trigger
  import qlt_pkg::*;
#(
  parameter int unsigned NUM_QUADS = 4,
  parameter int unsigned NUM_EDGE  = 2,
  parameter int unsigned CFG_W     = 16,
  localparam int unsigned CH         = NUM_QUADS * QUAD_BITS,
  localparam int unsigned NUM_UNITS  = 1 + NUM_EDGE,
  localparam int unsigned COMB_DEPTH = 1 << (2 * NUM_EDGE),
  localparam int unsigned UNIT_BITS  = NUM_QUADS * LUT_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             smp_valid_i,
  input  logic [CH-1:0]    smp_data_i,
  output logic             trig_o,
  output logic             armed_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [NUM_UNITS*UNIT_BITS-1:0] lut;
  logic [COMB_DEPTH-1:0]          comb;
  logic                           edge_en, tbl_wr, arm_wr, arm_val;
  logic [NUM_UNITS-1:0]           unit_match;

  qlt_cfg #(
    .NUM_QUADS (NUM_QUADS),
    .NUM_UNITS (NUM_UNITS),
    .CFG_W     (CFG_W),
    .COMB_DEPTH(COMB_DEPTH)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .lut_o    (lut),
    .comb_o   (comb),
    .edge_en_o(edge_en),
    .tbl_wr_o (tbl_wr),
    .arm_wr_o (arm_wr),
    .arm_val_o(arm_val)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    qlt_match #(.NUM_QUADS(NUM_QUADS)) u_match (
      .tbl_i  (lut[u*UNIT_BITS +: UNIT_BITS]),
      .data_i (smp_data_i),
      .match_o(unit_match[u])
    );
  end

  qlt_fire #(.NUM_EDGE(NUM_EDGE)) u_fire (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .smp_valid_i(smp_valid_i),
    .state_m_i  (unit_match[0]),
    .edge_m_i   (unit_match[NUM_UNITS-1:1]),
    .comb_i     (comb),
    .edge_en_i  (edge_en),
    .tbl_wr_i   (tbl_wr),
    .arm_wr_i   (arm_wr),
    .arm_val_i  (arm_val),
    .trig_o     (trig_o),
    .armed_o    (armed_o)
  );

  // R1: outputs low while the internal reset is held
  always_comb begin
    if (!rst_n_int) begin
      a_reset_quiet_r1: assert (!trig_o && !armed_o);
    end
  end
endmodule

// File: tb/quad_lut_trigger_tb.sv
`timescale 1ns/1ps
module quad_lut_trigger_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        smp_valid;
  logic [15:0] smp_data;
  logic        trig_o, armed_o;

  int checks = 0;
  int failures = 0;
  bit started = 1'b0;
  bit done = 1'b0;
  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  quad_lut_trigger u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .trig_o(trig_o), .armed_o(armed_o)
  );

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      bit v;
      @(posedge clk);
      v = smp_valid;
      @(negedge clk);
      if (v) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(trig_o === e, t, trig_o, e);
      end else if (started) begin
        chk(trig_o === 1'b0, "R10 idle cycle", trig_o, 1'b0);
      end
    end
  end

  task automatic cfg_wr(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic [15:0] d, input bit e, input string t);
    smp_valid = 1'b1; smp_data = d;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic drive_with_wr(input logic [15:0] d, input bit e, input string t,
                               input logic [1:0] a, input logic [15:0] w);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = w;
    smp_valid = 1'b1; smp_data = d;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    smp_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic idle_data(input logic [15:0] d);
    smp_valid = 1'b0; smp_data = d;
    @(negedge clk);
  endtask

  task automatic chk_armed(input logic e, input string t);
    chk(armed_o === e, t, armed_o, e);
  endtask

  function automatic bit vm_bit(input logic [15:0] v, input logic [15:0] m,
                                input int q, input int a);
    for (int k = 0; k < 4; k++) begin
      if (m[4*q+k] && (a[k] != v[4*q+k])) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic upload(input logic [15:0] v0, input logic [15:0] m0,
                        input logic [15:0] v1, input logic [15:0] m1,
                        input logic [15:0] v2, input logic [15:0] m2);
    for (int a = 0; a < 16; a++) begin
      logic [15:0] st;
      st = '0;
      for (int q = 0; q < 4; q++) begin
        st[0*4+q] = vm_bit(v0, m0, q, a);
        st[1*4+q] = vm_bit(v1, m1, q, a);
        st[2*4+q] = vm_bit(v2, m2, q, a);
      end
      cfg_wr(2'd0, st);
      cfg_wr(2'd1, 16'h0030 | 16'(a));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] comb;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    smp_valid = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    chk(trig_o === 1'b0, "R1 reset trig", trig_o, 1'b0);
    chk_armed(1'b0, "R1 reset armed");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    started = 1'b1;

    // R1: cleared tables never match
    cfg_wr(2'd3, 16'h0001);
    chk_armed(1'b1, "R9 arm bit");
    drive(16'h0000, 1'b0, "R1 empty tables");

    // R2 R4: full value/mask pattern
    upload(16'hA5C3, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF);
    chk_armed(1'b0, "R8 upload disarms");
    cfg_wr(2'd3, 16'h0001);
    drive(16'hA5C2, 1'b0, "R2 one quad differs");
    drive(16'h0000, 1'b0, "R2 no match");
    drive(16'hA5C3, 1'b1, "R4 pattern match");
    drive(16'hA5C3, 1'b0, "R7 one shot");
    chk_armed(1'b0, "R7 disarmed after fire");
    cfg_wr(2'd3, 16'h0001);
    drive(16'hA5C3, 1'b1, "R7 rearmed fires");

    // R2: partial mask on quad 1
    upload(16'h00F0, 16'h00F0, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF);
    cfg_wr(2'd3, 16'h0001);
    drive(16'h1204, 1'b0, "R2 masked quad wrong");
    idle_data(16'h12F4);
    chk_armed(1'b1, "R10 invalid sample ignored");
    drive(16'h12F4, 1'b1, "R2 don't-care quads");

    // R3: select write with wrong code ignored
    cfg_wr(2'd0, 16'h0FFF);
    cfg_wr(2'd1, 16'h0020);
    cfg_wr(2'd1, 16'h0040);
    cfg_wr(2'd3, 16'h0001);
    drive(16'h0000, 1'b0, "R3 no commit without code");
    drive(16'h00F0, 1'b1, "R3 tables intact");

    // R8: table writes disarm and block same-cycle fire
    cfg_wr(2'd3, 16'h0001);
    cfg_wr(2'd2, 16'h0000);
    chk_armed(1'b0, "R8 comb write disarms");
    drive(16'h00F0, 1'b0, "R8 disarmed no fire");
    cfg_wr(2'd3, 16'h0001);
    drive_with_wr(16'h00F0, 1'b0, "R8 same-cycle write", 2'd2, 16'h0000);
    chk_armed(1'b0, "R8 disarmed after write");

    // R5 R6: edge detectors through combining table
    upload(16'h0000, 16'h0000, 16'h0008, 16'h0008, 16'h0200, 16'h0200);
    for (int i = 0; i < 16; i++) begin
      comb[i] = (i[1] && !i[0]) || (i[2] && !i[3]);
    end
    cfg_wr(2'd2, comb);
    cfg_wr(2'd3, 16'h0003);
    drive(16'h0008, 1'b0, "R6 first sample after write");
    drive(16'h0008, 1'b0, "R5 steady high");
    drive(16'h0000, 1'b0, "R5 falling ch3 not selected");
    drive(16'h0008, 1'b1, "R5 rise detector 0");
    cfg_wr(2'd3, 16'h0003);
    drive(16'h0208, 1'b0, "R5 rise ch9 not selected");
    drive(16'h0008, 1'b1, "R5 fall detector 1");

    // R9: edge mode off, state table all ones
    cfg_wr(2'd3, 16'h0001);
    drive(16'h1234, 1'b1, "R9 edge mode off");
    cfg_wr(2'd3, 16'h0000);
    chk_armed(1'b0, "R9 disarm bit");
    drive(16'h1234, 1'b0, "R9 disarmed");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule